// File: doc/BRIEF.md
# Pixel-Count LCD Timing Generator

This block drives a parallel LCD panel from one pixel-clock domain. It produces horizontal sync, vertical sync, a data-enable strobe and the pixel bus. The horizontal position is an ordinary column counter that restarts every line period. The vertical timing does not use a line counter. Every vertical quantity (frame length, vsync width, vertical display window) is a linear pixel position inside the frame, `line * htotal + column`, so all of them are programmed in pixel clocks.

All timing, polarity and colour settings come in on input ports. The block copies them into an active set whenever it is idle, and at the last pixel of every running frame. A write in the middle of a frame therefore never tears that frame. Clearing the enable input lets the current frame finish, so the next mode starts from a clean frame boundary. Inside the display window the source pixel is passed through. If the source reports no valid pixel, a fill colour is sent instead. With recovery off, that fill colour is held until the frame ends. Outside the window a border colour is sent.

Top module: `lcd_pixtime_gen`

## Requirements
- R1: While running, the column counter counts 0 to `h_period_i-1`, restarts after that and also restarts at every frame start. hsync is active while the column is below `h_pulse_i`.
- R2: A running frame lasts exactly `frame_period_i` pixel clocks. vsync is active while the frame position is below `vsync_len_i`.
- R3: `de_o` is high only when the column lies in `[h_start_i, h_end_i]` and the frame position lies in `[v_start_i + skew_i, v_end_i + skew_i]`. All bounds are inclusive.
- R4: While running, `pix_o` carries `border_color_i` when data enable is low. It carries `pix_data_i` when data enable is high and `pix_valid_i` is 1.
- R5: `hsync_low_i` = 1 makes hsync active-low and `vsync_low_i` = 1 makes vsync active-low. With 0, each sync is active-high.
- R6: With `recover_en_i` = 1, `fill_color_i` replaces the pixel only on data-enable cycles where `pix_valid_i` is 0. Source pixels return on the next valid cycle.
- R7: With `recover_en_i` = 0, the first data-enable cycle with `pix_valid_i` = 0 starts fill output. Fill then covers every data-enable pixel up to the end of that frame. The next frame starts normally.
- R8: Every setting input is sampled into the active set only while idle or at the last pixel of a running frame. A change made mid-frame first shows at the next frame's position 0.
- R9: Clearing `enable_i` lets the current frame run to its end. After that, `de_o` = 0, `pix_o` = 0 and both syncs sit at their inactive level, regardless of `pix_valid_i` or `pix_data_i`.
- R10: While `rst_ni` is low, `hsync_o`, `vsync_o`, `de_o` and `pix_o` are all 0.
- R11: The edge that samples `enable_i` = 1 from idle starts frame position 0. The outputs for position p appear after the (p+1)-th following clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run request; a clear takes effect at frame end |
| h_period_i | input | H_W | Line period in pixel clocks |
| h_pulse_i | input | H_W | hsync width in pixel clocks |
| frame_period_i | input | F_W | Frame length in pixel clocks |
| vsync_len_i | input | F_W | vsync width in pixel clocks |
| h_start_i | input | H_W | First display column |
| h_end_i | input | H_W | Last display column |
| v_start_i | input | F_W | First display frame position before skew |
| v_end_i | input | F_W | Last display frame position before skew |
| skew_i | input | H_W | Offset added to both vertical bounds |
| hsync_low_i | input | 1 | hsync active-low |
| vsync_low_i | input | 1 | vsync active-low |
| recover_en_i | input | 1 | Resume source pixels after an underflow in the same frame |
| fill_color_i | input | PIX_W | Colour sent during underflow |
| border_color_i | input | PIX_W | Colour sent outside the display window |
| pix_valid_i | input | 1 | Source pixel available |
| pix_data_i | input | PIX_W | Source pixel |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_o | output | PIX_W | Pixel bus |

## Verification
Every output is registered once, after the decode of the current frame position. The outputs for position p, together with the source pixel offered for it, therefore show one edge after the counter holds p, and p+1 edges after the edge that saw the enable. The bench drives the source and the settings on the falling edge before the edge that consumes them. It samples on the next falling edge and keeps its own position counter on that schedule. A setting changed mid-frame is applied by the bench only at its own frame wrap, and a disable only after its own last position. Mid-frame changes and disables are therefore judged against the cycle in which they are due, not the cycle they were written.

// File: rtl/lcd_pixtime_pkg.sv
package lcd_pixtime_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/lcd_cfg_latch.sv
module lcd_cfg_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= '0;
    else if (load_i) q_q <= d_i;
  end

  assign q_o = q_q;
endmodule

// File: rtl/lcd_pos_counter.sv
module lcd_pos_counter
  import lcd_pixtime_pkg::*;
#(
  parameter int unsigned H_W = 12,
  parameter int unsigned F_W = 20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           enable_i,
  input  logic [H_W-1:0] h_per_i,
  input  logic [F_W-1:0] f_per_i,
  output logic           run_o,
  output logic [H_W-1:0] h_o,
  output logic [F_W-1:0] f_o,
  output logic           wrap_o,
  output logic           load_o
);
  run_state_e     st_q;
  logic [H_W-1:0] h_q;
  logic [F_W-1:0] f_q;
  logic           h_end, f_end;

  assign h_end = (h_q == h_per_i - H_W'(1));
  assign f_end = (f_q == f_per_i - F_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      h_q  <= '0;
      f_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          h_q <= '0;
          f_q <= '0;
          if (enable_i) st_q <= ST_RUN;
        end
        default: begin
          if (f_end) begin
            h_q <= '0;
            f_q <= '0;
            if (!enable_i) st_q <= ST_IDLE;
          end else begin
            f_q <= f_q + F_W'(1);
            h_q <= h_end ? '0 : h_q + H_W'(1);
          end
        end
      endcase
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign h_o    = h_q;
  assign f_o    = f_q;
  assign wrap_o = run_o & f_end;
  // active set tracks inputs while idle, refreshes at frame wrap
  assign load_o = ~run_o | wrap_o;
endmodule

// File: rtl/lcd_out_stage.sv
module lcd_out_stage #(
  parameter int unsigned H_W   = 12,
  parameter int unsigned F_W   = 20,
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic [H_W-1:0]   h_i,
  input  logic [F_W-1:0]   f_i,
  input  logic [H_W-1:0]   h_pw_i,
  input  logic [F_W-1:0]   vs_len_i,
  input  logic [H_W-1:0]   h_st_i,
  input  logic [H_W-1:0]   h_en_i,
  input  logic [F_W-1:0]   v_st_i,
  input  logic [F_W-1:0]   v_en_i,
  input  logic [H_W-1:0]   skew_i,
  input  logic             hs_low_i,
  input  logic             vs_low_i,
  input  logic             rec_i,
  input  logic [PIX_W-1:0] fill_i,
  input  logic [PIX_W-1:0] border_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             uf_o
);
  localparam int unsigned NSYNC = 2;

  logic [F_W-1:0]   sync_pos [NSYNC];
  logic [F_W-1:0]   sync_lim [NSYNC];
  logic [NSYNC-1:0] sync_hit, sync_pol, sync_q;
  logic [F_W:0]     v_lo, v_hi, f_ext;
  logic             h_win, v_win, de_n, use_fill, de_q, uf_q;
  logic [PIX_W-1:0] pix_q;

  assign sync_pos[0] = F_W'(h_i);
  assign sync_lim[0] = F_W'(h_pw_i);
  assign sync_pos[1] = f_i;
  assign sync_lim[1] = vs_len_i;
  assign sync_pol    = {vs_low_i, hs_low_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    assign sync_hit[g] = run_i && (sync_pos[g] < sync_lim[g]);
  end

  assign f_ext = {1'b0, f_i};
  assign v_lo  = {1'b0, v_st_i} + (F_W+1)'(skew_i);
  assign v_hi  = {1'b0, v_en_i} + (F_W+1)'(skew_i);
  assign h_win = (h_i >= h_st_i) && (h_i <= h_en_i);
  assign v_win = (f_ext >= v_lo) && (f_ext <= v_hi);
  assign de_n  = run_i && h_win && v_win;
  assign use_fill = ~pix_valid_i | uf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      de_q   <= 1'b0;
      pix_q  <= '0;
      uf_q   <= 1'b0;
    end else begin
      sync_q <= sync_hit ^ sync_pol;
      de_q   <= de_n;
      if (!run_i)        pix_q <= '0;
      else if (!de_n)    pix_q <= border_i;
      else if (use_fill) pix_q <= fill_i;
      else               pix_q <= pix_data_i;
      // sticky underflow without recovery, cleared per frame
      if (!run_i || wrap_i)                    uf_q <= 1'b0;
      else if (de_n && !pix_valid_i && !rec_i) uf_q <= 1'b1;
    end
  end

  assign hsync_o = sync_q[0];
  assign vsync_o = sync_q[1];
  assign de_o    = de_q;
  assign pix_o   = pix_q;
  assign uf_o    = uf_q;
endmodule

// File: rtl/lcd_pixtime_gen.sv
module lcd_pixtime_gen #(
  parameter int unsigned H_W   = 12,
  parameter int unsigned F_W   = 20,
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [H_W-1:0]   h_period_i,
  input  logic [H_W-1:0]   h_pulse_i,
  input  logic [F_W-1:0]   frame_period_i,
  input  logic [F_W-1:0]   vsync_len_i,
  input  logic [H_W-1:0]   h_start_i,
  input  logic [H_W-1:0]   h_end_i,
  input  logic [F_W-1:0]   v_start_i,
  input  logic [F_W-1:0]   v_end_i,
  input  logic [H_W-1:0]   skew_i,
  input  logic             hsync_low_i,
  input  logic             vsync_low_i,
  input  logic             recover_en_i,
  input  logic [PIX_W-1:0] fill_color_i,
  input  logic [PIX_W-1:0] border_color_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_data_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [PIX_W-1:0] pix_o
);
  localparam int unsigned CFG_W = 5*H_W + 4*F_W + 2*PIX_W + 3;

  logic [CFG_W-1:0] cfg_d, cfg_q;
  logic [H_W-1:0]   a_hper, a_hpw, a_hst, a_hen, a_skew;
  logic [F_W-1:0]   a_fper, a_vsl, a_vst, a_ven;
  logic             a_hlow, a_vlow, a_rec;
  logic [PIX_W-1:0] a_fill, a_border;
  logic             run_w, wrap_w, load_w, uf_w;
  logic [H_W-1:0]   h_w;
  logic [F_W-1:0]   f_w;

  assign cfg_d = {h_period_i, h_pulse_i, h_start_i, h_end_i, skew_i,
                  frame_period_i, vsync_len_i, v_start_i, v_end_i,
                  hsync_low_i, vsync_low_i, recover_en_i,
                  fill_color_i, border_color_i};

  assign {a_hper, a_hpw, a_hst, a_hen, a_skew,
          a_fper, a_vsl, a_vst, a_ven,
          a_hlow, a_vlow, a_rec,
          a_fill, a_border} = cfg_q;

  lcd_cfg_latch #(.W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .d_i    (cfg_d),
    .q_o    (cfg_q)
  );

  lcd_pos_counter #(.H_W(H_W), .F_W(F_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .h_per_i  (a_hper),
    .f_per_i  (a_fper),
    .run_o    (run_w),
    .h_o      (h_w),
    .f_o      (f_w),
    .wrap_o   (wrap_w),
    .load_o   (load_w)
  );

  lcd_out_stage #(.H_W(H_W), .F_W(F_W), .PIX_W(PIX_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_w),
    .wrap_i      (wrap_w),
    .h_i         (h_w),
    .f_i         (f_w),
    .h_pw_i      (a_hpw),
    .vs_len_i    (a_vsl),
    .h_st_i      (a_hst),
    .h_en_i      (a_hen),
    .v_st_i      (a_vst),
    .v_en_i      (a_ven),
    .skew_i      (a_skew),
    .hs_low_i    (a_hlow),
    .vs_low_i    (a_vlow),
    .rec_i       (a_rec),
    .fill_i      (a_fill),
    .border_i    (a_border),
    .pix_valid_i (pix_valid_i),
    .pix_data_i  (pix_data_i),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .de_o        (de_o),
    .pix_o       (pix_o),
    .uf_o        (uf_w)
  );
endmodule

// File: rtl/lcd_pixtime_chk.sv
module lcd_pixtime_chk #(
  parameter int unsigned H_W   = 12,
  parameter int unsigned F_W   = 20,
  parameter int unsigned PIX_W = 24,
  parameter int unsigned CFG_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             wrap_i,
  input logic             uf_i,
  input logic [H_W-1:0]   h_i,
  input logic [F_W-1:0]   f_i,
  input logic [H_W-1:0]   h_per_i,
  input logic [CFG_W-1:0] cfg_i,
  input logic             de_i,
  input logic [PIX_W-1:0] pix_i
);
  // R1
  col_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && h_per_i != '0) |-> (h_i < h_per_i));

  // R2
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (f_i == '0 && h_i == '0));

  // R9
  run_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_i) |=> run_i);

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!de_i && pix_i == '0));

  // R7
  fill_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_i && !wrap_i) |=> uf_i);

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wrap_i) |=> $stable(cfg_i));
endmodule

bind lcd_pixtime_gen lcd_pixtime_chk #(
  .H_W(H_W), .F_W(F_W), .PIX_W(PIX_W), .CFG_W(CFG_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .run_i   (run_w),
  .wrap_i  (wrap_w),
  .uf_i    (uf_w),
  .h_i     (h_w),
  .f_i     (f_w),
  .h_per_i (a_hper),
  .cfg_i   (cfg_q),
  .de_i    (de_o),
  .pix_i   (pix_o)
);

// File: tb/lcd_pixtime_gen_test.sv
module lcd_pixtime_gen_test;
  localparam int H_W = 12, F_W = 20, PIX_W = 24;

  logic clk_i = 1'b0, rst_ni = 1'b0, enable_i = 1'b0;
  logic [H_W-1:0]   h_period_i, h_pulse_i, h_start_i, h_end_i, skew_i;
  logic [F_W-1:0]   frame_period_i, vsync_len_i, v_start_i, v_end_i;
  logic             hsync_low_i, vsync_low_i, recover_en_i, pix_valid_i;
  logic [PIX_W-1:0] fill_color_i, border_color_i, pix_data_i;
  logic             hsync_o, vsync_o, de_o;
  logic [PIX_W-1:0] pix_o;

  always #10 clk_i = ~clk_i;

  lcd_pixtime_gen #(.H_W(H_W), .F_W(F_W), .PIX_W(PIX_W)) uut (.*);

  int n_chk = 0, n_err = 0, cyc = 0;
  string req = "";
  int bpos = 0, bfr = 0;
  bit running = 0, uf_m = 0;
  int drop_lo = -1, drop_hi = -1, drop_fr = -1;
  int a_hper, a_hpw, a_hst, a_hen, a_skew, a_fper, a_vsl, a_vst, a_ven;
  bit a_hlow, a_vlow, a_rec;
  logic [PIX_W-1:0] a_fill, a_border;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (all requirements) got cycles=%0d exp <=150000", cyc);
      summary();
    end
  end

  task automatic copy_cfg();
    a_hper = int'(h_period_i); a_hpw = int'(h_pulse_i); a_hst = int'(h_start_i);
    a_hen = int'(h_end_i); a_skew = int'(skew_i); a_fper = int'(frame_period_i);
    a_vsl = int'(vsync_len_i); a_vst = int'(v_start_i); a_ven = int'(v_end_i);
    a_hlow = hsync_low_i; a_vlow = vsync_low_i; a_rec = recover_en_i;
    a_fill = fill_color_i; a_border = border_color_i;
  endtask

  task automatic cmp(input bit ehs, input bit evs, input bit ede, input logic [PIX_W-1:0] epix);
    n_chk++;
    if (hsync_o !== ehs || vsync_o !== evs || de_o !== ede || pix_o !== epix) begin
      n_err++;
      $display("FAIL %s pos=%0d got hs=%b vs=%b de=%b pix=%h exp hs=%b vs=%b de=%b pix=%h",
               req, bpos, hsync_o, vsync_o, de_o, pix_o, ehs, evs, ede, epix);
    end
  endtask

  // one running position: drive source for bpos, check it one edge later
  task automatic step();
    bit v, ehs, evs, ede, drop;
    int col;
    logic [PIX_W-1:0] epix, d;
    drop = (drop_fr < 0 || bfr == drop_fr) && bpos >= drop_lo && bpos <= drop_hi;
    v = !drop;
    d = PIX_W'(24'h5A0000 + bpos);
    pix_valid_i = v; pix_data_i = d;
    col = bpos % a_hper;
    ehs = (col < a_hpw) ^ a_hlow;
    evs = (bpos < a_vsl) ^ a_vlow;
    ede = col >= a_hst && col <= a_hen && bpos >= a_vst + a_skew && bpos <= a_ven + a_skew;
    epix = !ede ? a_border : ((v && !uf_m) ? d : a_fill);
    if (ede && !v && !a_rec) uf_m = 1;
    @(negedge clk_i);
    cmp(ehs, evs, ede, epix);
    if (bpos == a_fper - 1) begin
      bpos = 0; bfr++; uf_m = 0;
      if (!enable_i) running = 0;
      copy_cfg();
    end else bpos++;
  endtask

  task automatic run_n(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic idle_step();
    @(negedge clk_i);
    cmp(a_hlow, a_vlow, 1'b0, '0);
  endtask

  task automatic settle();
    @(negedge clk_i); @(negedge clk_i);
    copy_cfg();
  endtask

  // R11: position 0 appears after the second edge following enable
  task automatic start_run();
    enable_i = 1'b1;
    idle_step();
    copy_cfg();
    bpos = 0; bfr = 0; uf_m = 0; running = 1;
  endtask

  task automatic stop_run();
    enable_i = 1'b0;
    while (running) step();
    for (int i = 0; i < 3; i++) idle_step();
  endtask

  task automatic set_nominal();
    h_period_i = 10; h_pulse_i = 2; frame_period_i = 60; vsync_len_i = 10;
    h_start_i = 4; h_end_i = 8; v_start_i = 20; v_end_i = 49; skew_i = 0;
    hsync_low_i = 0; vsync_low_i = 0; recover_en_i = 1;
    fill_color_i = 24'h0000FF; border_color_i = 24'h123456;
    pix_valid_i = 1; pix_data_i = '0;
  endtask

  task automatic t_reset();
    req = "R10";
    set_nominal();
    rst_ni = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      a_hlow = 0; a_vlow = 0;
      cmp(1'b0, 1'b0, 1'b0, '0);
    end
    rst_ni = 1'b1;
  endtask

  task automatic t_nominal();
    req = "R1 R2 R3 R4 R11";
    settle();
    start_run();
    run_n(120);
  endtask

  task automatic t_polarity();
    req = "R5 R8";
    run_n(25);
    hsync_low_i = 1; vsync_low_i = 1;
    run_n(95);
    hsync_low_i = 0;
    run_n(70);
    vsync_low_i = 0;
    run_n(60);
  endtask

  task automatic t_geometry();
    req = "R2 R3 R8";
    run_n(10);
    skew_i = 3; h_start_i = 2; frame_period_i = 40; vsync_len_i = 20; v_end_i = 29;
    run_n(130);
    req = "R1 R2 R8";
    h_pulse_i = 3; skew_i = 0; h_start_i = 4; frame_period_i = 60;
    vsync_len_i = 10; v_end_i = 49;
    run_n(130);
  endtask

  task automatic t_recover();
    req = "R6";
    drop_lo = 24; drop_hi = 26; drop_fr = -1;
    run_n(120);
    drop_lo = -1; drop_hi = -1;
  endtask

  task automatic t_sticky();
    req = "R7";
    stop_run();
    recover_en_i = 0;
    settle();
    drop_lo = 34; drop_hi = 34; drop_fr = 0;
    start_run();
    run_n(120);
    drop_lo = -1; drop_hi = -1; drop_fr = -1;
  endtask

  task automatic t_disable();
    req = "R9";
    run_n(10);
    stop_run();
    for (int i = 0; i < 6; i++) begin
      pix_valid_i = i[0]; pix_data_i = PIX_W'(24'hC0FFEE + i);
      idle_step();
    end
    req = "R11";
    recover_en_i = 1;
    settle();
    start_run();
    run_n(60);
    req = "R9";
    stop_run();
  endtask

  initial begin
    t_reset();
    t_nominal();
    t_polarity();
    t_geometry();
    t_recover();
    t_sticky();
    t_disable();
    summary();
  end
endmodule